// File: doc/BRIEF.md
# Multi-Channel Sample/Convert Sequencer

This block orders the work of a sampling analog-to-digital converter that has up to four sample/hold channels. Software or a buffer controller configures how many channels take part (one, two or four), whether those channels are captured together on one trigger or each on a trigger of its own, whether successive sequences alternate between two prepared input selections, and whether channel 0 walks through a set of analog inputs chosen by a scan mask. The block drives the track/hold controls, the input number each channel is connected to, a one-cycle conversion-start pulse per channel, and a one-cycle result write strobe that carries the channel number.

A sequence begins when the sample-start input is seen in the idle state. Acquisition then runs until any of the three trigger inputs (software, timer, external) is seen, after which conversions are issued one at a time. Each one waits for the converter's done handshake before the next may start. The converter and result storage lie outside the block. An interrupt-event input from the buffer controller puts the scan position and the alternation state back to their starting points.

Top module: `adc_seq_top`

## Requirements
- R1: `cfg_chans` selects the channel count: code 0 gives one channel, code 1 gives two, codes 2 and 3 give four. A sequence produces exactly that many write strobes, with `wr_ch` counting up from 0.
- R2: With `cfg_simul`=1, every selected channel tracks (`sh_track` bits 0..N-1 high) during the single acquisition, and one trigger causes all N conversions back to back with no further trigger.
- R3: With `cfg_simul`=0, `sh_track` has only the bit of the current channel high; each channel needs its own trigger, and acquisition of the next channel starts by itself in the cycle after the previous channel's write strobe.
- R4: With one channel selected, the value of `cfg_simul` changes nothing at the outputs.
- R5: `samp_start` seen in idle starts acquisition in the next cycle. Any of `trig_sw`, `trig_tmr`, `trig_ext` seen during acquisition ends it, and `conv_start` is high in the following cycle; a trigger seen while idle is ignored.
- R6: `conv_start` lasts one cycle; no new `conv_start` occurs until `conv_done` has answered the previous one; `wr_stb` is high for one cycle, in the cycle after `conv_done` is seen, with `wr_ch` equal to that conversion's `conv_ch`.
- R7: `busy` rises together with the first `conv_start` of a sequence and falls in the cycle after the last write strobe, staying high in between (including sequential re-acquisitions).
- R8: With `cfg_alt`=1, sequences use `mux_a_sel` and `mux_b_sel` in turn, starting with A; with `cfg_alt`=0 every channel's `in_sel` slice is its `mux_a_sel` slice (slice c at bits c*IN_W upward).
- R9: With `cfg_scan`=1 and set A in use, channel 0's input is the lowest mask bit at or above the scan position; each set-A sequence moves the position past the input used, wrapping to the lowest set bit after the highest; an all-zero mask selects input 0.
- R10: `irq_event` returns the scan position to the lowest enabled input and the alternation state to set A, taking priority over an update from a sequence ending on the same edge.
- R11: Reset leaves the block idle: `busy`, `sh_track`, `conv_start`, `wr_stb` low and set A, scan position 0 selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_start | input | 1 | Start acquisition (seen in idle) |
| trig_sw | input | 1 | Software conversion trigger |
| trig_tmr | input | 1 | Timer time-out trigger |
| trig_ext | input | 1 | External event trigger |
| conv_done | input | 1 | Converter finished the current conversion |
| irq_event | input | 1 | Interrupt event from the buffer controller |
| cfg_chans | input | 2 | Channel count code |
| cfg_simul | input | 1 | 1 = capture all channels on one trigger |
| cfg_alt | input | 1 | 1 = alternate input sets A and B per sequence |
| cfg_scan | input | 1 | 1 = channel 0 of set A scans the mask |
| scan_mask | input | NUM_IN | Inputs enabled for scanning |
| mux_a_sel | input | 4*IN_W | Set A input number per channel |
| mux_b_sel | input | 4*IN_W | Set B input number per channel |
| sh_track | output | 4 | Per channel: 1 = tracking, 0 = holding |
| in_sel | output | 4*IN_W | Input number driven to each channel |
| conv_start | output | 1 | One-cycle conversion start |
| conv_ch | output | 2 | Channel being converted |
| wr_stb | output | 1 | One-cycle result write strobe |
| wr_ch | output | 2 | Channel of the written result |
| busy | output | 1 | Sequence in conversion |

## Verification
Random sequences draw the channel count, the capture mode, alternation, scanning and the mask together, with random converter latency and a randomly chosen trigger source, so that the count and order of write strobes separate the channel-count codes and the track pattern and trigger count separate simultaneous from sequential capture. Directed runs cover a zero mask, a sparse mask that must wrap, an interrupt event in the middle of a scan and alternation run, and triggers presented while idle. The bench keeps its own model of the alternation state and scan position, so a wrong set choice, a wrong wrap point or a missed restart shows up as a wrong input number at the start of acquisition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned MAX_CH = 4;
    localparam int unsigned CH_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE
    } seq_state_e;

    typedef struct packed {
        logic [CH_W-1:0] nch_m1;
        logic            simul;
    } seq_cfg_t;

    typedef struct packed {
        logic            conv_start;
        logic            wr_stb;
        logic [CH_W-1:0] ch;
        logic            busy;
        logic            seq_done;
    } seq_ctl_t;

    function automatic logic [CH_W-1:0] chans_minus_one(logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [MAX_CH-1:0] chan_mask(logic [CH_W-1:0] nch_m1);
        logic [MAX_CH-1:0] m;
        for (int i = 0; i < MAX_CH; i++) begin
            m[i] = (i <= int'(nch_m1));
        end
        return m;
    endfunction

endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
    parameter int unsigned NUM_IN = 16,
    localparam int unsigned IN_W  = $clog2(NUM_IN),
    localparam int unsigned POS_W = IN_W + 1
) (
    input  logic [NUM_IN-1:0] mask,
    input  logic [POS_W-1:0]  start_pos,
    output logic [IN_W-1:0]   pick
);
    logic [IN_W-1:0] hi_pick;
    logic [IN_W-1:0] lo_pick;
    logic            hi_found;
    logic            lo_found;

    always_comb begin
        hi_pick  = '0;
        lo_pick  = '0;
        hi_found = 1'b0;
        lo_found = 1'b0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (mask[i]) begin
                lo_pick  = IN_W'(i);
                lo_found = 1'b1;
                if (i >= int'(start_pos)) begin
                    hi_pick  = IN_W'(i);
                    hi_found = 1'b1;
                end
            end
        end
        if (hi_found)      pick = hi_pick;
        else if (lo_found) pick = lo_pick;
        else               pick = '0;
    end
endmodule

// File: rtl/adc_seq_ctx.sv
module adc_seq_ctx #(
    parameter int unsigned NUM_IN = 16,
    localparam int unsigned IN_W  = $clog2(NUM_IN),
    localparam int unsigned POS_W = IN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seq_done,
    input  logic             irq_event,
    input  logic             cfg_alt,
    input  logic             cfg_scan,
    input  logic [IN_W-1:0]  used_pick,
    output logic             set_b,
    output logic [POS_W-1:0] scan_pos
);
    logic alt_q;

    assign set_b = cfg_alt & alt_q;

    always_ff @(posedge clk) begin
        if (rst || irq_event) begin
            alt_q    <= 1'b0;
            scan_pos <= '0;
        end else if (seq_done) begin
            alt_q <= cfg_alt ? ~alt_q : 1'b0;
            if (!set_b && cfg_scan) begin
                scan_pos <= POS_W'(used_pick) + POS_W'(1);
            end
        end
    end
endmodule

// File: rtl/adc_in_route.sv
module adc_in_route
    import adc_seq_pkg::*;
#(
    parameter int unsigned NUM_IN = 16,
    localparam int unsigned IN_W  = $clog2(NUM_IN),
    localparam int unsigned SEL_W = MAX_CH * IN_W
) (
    input  logic             set_b,
    input  logic             scan_on,
    input  logic [IN_W-1:0]  scan_pick,
    input  logic [SEL_W-1:0] set_a_sel,
    input  logic [SEL_W-1:0] set_b_sel,
    output logic [SEL_W-1:0] route
);
    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
        logic [IN_W-1:0] a_val;
        if (c == 0) begin : g_scan
            assign a_val = scan_on ? scan_pick : set_a_sel[c*IN_W +: IN_W];
        end else begin : g_fixed
            assign a_val = set_a_sel[c*IN_W +: IN_W];
        end
        assign route[c*IN_W +: IN_W] = set_b ? set_b_sel[c*IN_W +: IN_W] : a_val;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_start,
    input  logic              trig,
    input  logic              conv_done,
    input  seq_cfg_t          cfg,
    output seq_ctl_t          ctl,
    output logic [MAX_CH-1:0] track
);
    seq_state_e      state;
    logic [CH_W-1:0] ch_idx;
    logic            busy_q;
    logic            last;

    assign last = (ch_idx == cfg.nch_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ch_idx <= '0;
            busy_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (samp_start) begin
                        state  <= ST_ACQ;
                        ch_idx <= '0;
                    end
                end
                ST_ACQ: begin
                    if (trig) begin
                        state  <= ST_ISSUE;
                        busy_q <= 1'b1;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (last) begin
                        state  <= ST_IDLE;
                        busy_q <= 1'b0;
                        ch_idx <= '0;
                    end else begin
                        ch_idx <= ch_idx + CH_W'(1);
                        state  <= cfg.simul ? ST_ISSUE : ST_ACQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.conv_start = (state == ST_ISSUE);
        ctl.wr_stb     = (state == ST_WRITE);
        ctl.ch         = ch_idx;
        ctl.busy       = busy_q;
        ctl.seq_done   = (state == ST_WRITE) && last;
        if (state != ST_ACQ)  track = '0;
        else if (cfg.simul)   track = chan_mask(cfg.nch_m1);
        else                  track = MAX_CH'(1) << ch_idx;
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int unsigned NUM_IN = 16,
    localparam int unsigned IN_W  = $clog2(NUM_IN),
    localparam int unsigned POS_W = IN_W + 1,
    localparam int unsigned SEL_W = MAX_CH * IN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_start,
    input  logic              trig_sw,
    input  logic              trig_tmr,
    input  logic              trig_ext,
    input  logic              conv_done,
    input  logic              irq_event,
    input  logic [1:0]        cfg_chans,
    input  logic              cfg_simul,
    input  logic              cfg_alt,
    input  logic              cfg_scan,
    input  logic [NUM_IN-1:0] scan_mask,
    input  logic [SEL_W-1:0]  mux_a_sel,
    input  logic [SEL_W-1:0]  mux_b_sel,
    output logic [MAX_CH-1:0] sh_track,
    output logic [SEL_W-1:0]  in_sel,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    output logic              wr_stb,
    output logic [CH_W-1:0]   wr_ch,
    output logic              busy
);
    seq_cfg_t         cfg;
    seq_ctl_t         ctl;
    logic             set_b;
    logic [POS_W-1:0] scan_pos;
    logic [IN_W-1:0]  scan_pick;

    assign cfg.nch_m1 = chans_minus_one(cfg_chans);
    assign cfg.simul  = cfg_simul;

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .samp_start (samp_start),
        .trig       (trig_sw | trig_tmr | trig_ext),
        .conv_done  (conv_done),
        .cfg        (cfg),
        .ctl        (ctl),
        .track      (sh_track)
    );

    adc_scan_pick #(.NUM_IN(NUM_IN)) u_pick (
        .mask      (scan_mask),
        .start_pos (scan_pos),
        .pick      (scan_pick)
    );

    adc_seq_ctx #(.NUM_IN(NUM_IN)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .seq_done  (ctl.seq_done),
        .irq_event (irq_event),
        .cfg_alt   (cfg_alt),
        .cfg_scan  (cfg_scan),
        .used_pick (scan_pick),
        .set_b     (set_b),
        .scan_pos  (scan_pos)
    );

    adc_in_route #(.NUM_IN(NUM_IN)) u_route (
        .set_b     (set_b),
        .scan_on   (cfg_scan),
        .scan_pick (scan_pick),
        .set_a_sel (mux_a_sel),
        .set_b_sel (mux_b_sel),
        .route     (in_sel)
    );

    assign conv_start = ctl.conv_start;
    assign conv_ch    = ctl.ch;
    assign wr_stb     = ctl.wr_stb;
    assign wr_ch      = ctl.ch;
    assign busy       = ctl.busy;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_start,
    input logic       conv_done,
    input logic       wr_stb,
    input logic [1:0] wr_ch,
    input logic       busy,
    input logic [3:0] sh_track,
    input logic [1:0] cfg_chans,
    input logic       cfg_simul
);
    logic       pend;
    logic [2:0] nch;

    assign nch = (cfg_chans == 2'd0) ? 3'd1 : (cfg_chans == 2'd1) ? 3'd2 : 3'd4;

    always_ff @(posedge clk) begin
        if (rst)             pend <= 1'b0;
        else if (conv_start) pend <= 1'b1;
        else if (conv_done)  pend <= 1'b0;
    end

    AST_WR_CH_IN_RANGE: assert property (@(posedge clk) disable iff (rst) wr_stb |-> ({1'b0, wr_ch} < nch)); // R1
    AST_HOLD_WHILE_CONVERTING: assert property (@(posedge clk) disable iff (rst) conv_start |-> (sh_track == 4'd0)); // R2
    AST_SEQ_SINGLE_TRACK: assert property (@(posedge clk) disable iff (rst) !cfg_simul |-> $onehot0(sh_track)); // R3
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) conv_start |=> !conv_start); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) conv_start |-> !pend); // R6
    AST_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) wr_stb |-> $past(conv_done)); // R6
    AST_BUSY_WHEN_STARTING: assert property (@(posedge clk) disable iff (rst) conv_start |-> busy); // R7
    AST_BUSY_FALLS_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> $past(wr_stb)); // R7
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .wr_stb     (wr_stb),
    .wr_ch      (wr_ch),
    .busy       (busy),
    .sh_track   (sh_track),
    .cfg_chans  (cfg_chans),
    .cfg_simul  (cfg_simul)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
    localparam int NIN  = 16;
    localparam int INW  = 4;
    localparam int SELW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            samp_start = 0, trig_sw = 0, trig_tmr = 0, trig_ext = 0;
    logic            conv_done = 0, irq_event = 0;
    logic [1:0]      cfg_chans = 0;
    logic            cfg_simul = 0, cfg_alt = 0, cfg_scan = 0;
    logic [NIN-1:0]  scan_mask = 0;
    logic [SELW-1:0] mux_a_sel = 16'h3210, mux_b_sel = 16'hBA98;
    logic [3:0]      sh_track;
    logic [SELW-1:0] in_sel;
    logic            conv_start, wr_stb, busy;
    logic [1:0]      conv_ch, wr_ch;

    int checks = 0;
    int errors = 0;
    logic alt_m = 0;
    int   pos_m = 0;

    always #10 clk = ~clk;

    adc_seq_top i_adc_seq_top (.*);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nch_of(logic [1:0] code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic int pick_m(logic [NIN-1:0] m, int pos);
        for (int i = pos; i < NIN; i++) if (m[i]) return i;
        for (int i = 0; i < NIN; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic logic [SELW-1:0] exp_sel();
        logic [SELW-1:0] e;
        logic selb;
        selb = cfg_alt & alt_m;
        e = selb ? mux_b_sel : mux_a_sel;
        if (!selb && cfg_scan) e[INW-1:0] = INW'(pick_m(scan_mask, pos_m));
        return e;
    endfunction

    task automatic fire_trigger();
        int s = $urandom_range(0, 2);
        if (s == 0) trig_sw = 1; else if (s == 1) trig_tmr = 1; else trig_ext = 1;
        @(negedge clk);
        trig_sw = 0; trig_tmr = 0; trig_ext = 0;
    endtask

    task automatic run_seq();
        int n = nch_of(cfg_chans);
        logic selb = cfg_alt & alt_m;
        int used = pick_m(scan_mask, pos_m);
        @(negedge clk);
        samp_start = 1;
        @(negedge clk);
        samp_start = 0;
        chk(in_sel == exp_sel(), "R8/R9 in_sel", int'(in_sel), int'(exp_sel()));
        chk(busy == 0, "R7 busy before trigger", busy, 0);
        for (int k = 0; k < n; k++) begin
            if (k == 0 || !cfg_simul) begin
                if (cfg_simul) chk(sh_track == 4'((1 << n) - 1), "R2 all track", sh_track, (1 << n) - 1);
                else           chk(sh_track == 4'(1 << k), "R3/R4 one track", sh_track, 1 << k);
                repeat ($urandom_range(0, 3)) begin
                    @(negedge clk);
                    chk(conv_start == 0, "R5 no start before trigger", conv_start, 0);
                end
                fire_trigger();
            end
            chk(conv_start == 1 && conv_ch == 2'(k), "R5/R1 conv_start channel", {conv_start, conv_ch}, 4 + k);
            chk(busy == 1 && sh_track == 0, "R7/R2 busy and hold", {busy, sh_track}, 16);
            @(negedge clk);
            repeat ($urandom_range(0, 4)) begin
                chk(conv_start == 0 && wr_stb == 0, "R6 waits for done", {conv_start, wr_stb}, 0);
                @(negedge clk);
            end
            conv_done = 1;
            @(negedge clk);
            conv_done = 0;
            chk(wr_stb == 1 && wr_ch == 2'(k), "R6/R1 write strobe", {wr_stb, wr_ch}, 4 + k);
            @(negedge clk);
            chk(wr_stb == 0, "R6 write one cycle", wr_stb, 0);
            if (k == n - 1) begin
                chk(busy == 0 && sh_track == 0 && conv_start == 0, "R7/R1 idle after last", {busy, sh_track, conv_start}, 0);
            end else begin
                chk(busy == 1, "R7 busy between channels", busy, 1);
            end
        end
        if (!selb && cfg_scan) pos_m = used + 1;
        alt_m = cfg_alt ? ~alt_m : 1'b0;
        chk(in_sel == exp_sel(), "R8/R9 next selection", int'(in_sel), int'(exp_sel()));
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_event = 1;
        @(negedge clk);
        irq_event = 0;
        alt_m = 0;
        pos_m = 0;
        chk(in_sel == exp_sel(), "R10 restart", int'(in_sel), int'(exp_sel()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(busy == 0 && sh_track == 0 && conv_start == 0 && wr_stb == 0, "R11 reset outputs", {busy, sh_track, conv_start, wr_stb}, 0);
        chk(in_sel == mux_a_sel, "R11 reset set A", int'(in_sel), int'(mux_a_sel));
        rst = 0;
        @(negedge clk);
        // R5: trigger while idle is ignored
        fire_trigger();
        chk(conv_start == 0 && busy == 0 && sh_track == 0, "R5 idle trigger ignored", {conv_start, busy}, 0);
        // R1/R4: single channel, both capture modes
        cfg_chans = 0; cfg_simul = 0; run_seq();
        cfg_simul = 1; run_seq();
        // R2 / R3 four channels, code 3
        cfg_chans = 3; cfg_simul = 1; run_seq();
        cfg_simul = 0; run_seq();
        // R9: zero mask selects input 0
        cfg_chans = 1; cfg_scan = 1; scan_mask = 16'h0000; mux_a_sel = 16'h777F; run_seq();
        // R9: sparse mask wraps after highest
        scan_mask = 16'h8024;
        repeat (4) run_seq();
        // R8 + R10: alternation then interrupt restart
        cfg_alt = 1; run_seq(); run_seq(); run_seq();
        pulse_irq();
        run_seq();
        // random mix
        for (int t = 0; t < 60; t++) begin
            cfg_chans = 2'($urandom_range(0, 3));
            cfg_simul = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) cfg_alt = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) cfg_scan = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 4) == 0) scan_mask = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
            mux_a_sel = 16'($urandom);
            mux_b_sel = 16'($urandom);
            if ($urandom_range(0, 9) == 0) pulse_irq();
            run_seq();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule